// File: doc/BRIEF.md
# Exception State and Interrupt Control Registers

This block keeps the exception state of a small multicycle processor core. It holds three architectural words: a saved program counter for the faulting instruction, a cause word with an exception code and a set of sticky pending flags for hardware interrupt lines, and a status word with an interrupt mask and a three-level stack of privilege and interrupt-enable pairs.

When the core's control sequencer takes an exception, it pulses a request with a four-bit code and the current program counter. The program counter already points one instruction past the faulting one. On that edge the block does four things:
- it saves the address minus one instruction width;
- it records the code;
- it pushes the mode stack, which enters kernel mode with interrupts off;
- on the next cycle it presents the fixed handler entry address with a one-cycle redirect strobe.

Handler software reads and writes the three words through a simple port. It leaves through a return pulse that pops the mode stack. External interrupt lines are latched into pending flags at all times. An interrupt request is raised when the current enable bit is set and an unmasked flag is pending.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After a synchronous reset, the saved PC, cause and status words read as zero, and both `irq_req` and `redirect_valid` are 0.
- R2: On a cycle with `exc_req` high, the saved PC is loaded with `cur_pc` minus 4.
- R3: `redirect_valid` is 1 exactly in the cycle after a cycle with `exc_req` high. In that cycle `redirect_pc` is 0x80000080.
- R4: On exception entry, cause bits 5:2 take `exc_code`. The codes are 0 external interrupt, 4 load or fetch address error, 5 store address error, 6 fetch bus error, 7 data bus error, 8 system call, 9 breakpoint, 10 reserved instruction and 12 overflow. Cause bits outside 15:10 and 5:2 always read zero.
- R5: Cause bit 10+i becomes 1 on the edge where `hw_irq[i]` is high, whatever the enable and mask bits are. It stays 1 until a software write to the cause word. That write loads bits 15:10 from the write data, ORed with the lines that are high in the same cycle.
- R6: On exception entry, status bits 5:2 take the old bits 3:0 and bits 1:0 become 00. The pair layout is k in the odd bit (1 = user) and e in the even bit (1 = enabled). The mask in bits 15:8 is unchanged.
- R7: On `eret`, status bits 3:0 take the old bits 5:2, and bits 5:4 keep their value.
- R8: `irq_req` is registered. It is 1 in the cycle after one in which status bit 0 is 1 and, for some i, both cause bit 10+i and status bit 10+i are 1.
- R9: Exception entry overrides a same-cycle software write to any of the three words and overrides `eret`. `eret` overrides a same-cycle status write.
- R10: `rd_data` shows, one cycle after `rd_sel`, the status word (0), the cause word (1), the saved PC (2) or zero (3).
- R11: A software write sets the full saved PC. A status write sets bits 15:8 and 5:0 only, and the status bits outside those fields read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Take an exception this cycle |
| exc_code | input | 4 | Exception code recorded on entry |
| cur_pc | input | 32 | Program counter, already advanced past the faulting instruction |
| eret | input | 1 | Return from exception, pops the mode stack |
| hw_irq | input | 6 | External interrupt lines |
| sw_we_epc | input | 1 | Software write of the saved PC |
| sw_we_cause | input | 1 | Software write of the cause word |
| sw_we_status | input | 1 | Software write of the status word |
| sw_wdata | input | 32 | Software write data |
| rd_sel | input | 2 | Read select: 0 status, 1 cause, 2 saved PC, 3 zero |
| rd_data | output | 32 | Registered read data |
| redirect_valid | output | 1 | Handler redirect strobe |
| redirect_pc | output | 32 | Handler entry address |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
A corrupted mode stack appears at the ports within one cycle. `irq_req` stays high or low against the enable bit, and a status read one cycle later shows the wrong pairs. After a later return the error appears again, shifted by one pair. A lost or stuck pending flag changes `irq_req` on the next cycle while interrupts are enabled. While they are disabled, it can be seen only through a cause read. For that reason the bench reads the cause word in the cycles where interrupts are off. A bad saved PC or code shows up only when software reads it back, so every entry is followed by reads of those words.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int CODE_W      = 4;
  localparam int CODE_LO     = 2;
  localparam int PEND_LO     = 10;
  localparam int MASK_LO     = 8;
  localparam int MASK_W      = 8;
  localparam int STACK_W     = 6;

  typedef enum logic [CODE_W-1:0] {
    XC_EXT_IRQ   = 4'd0,
    XC_ADDR_LD   = 4'd4,
    XC_ADDR_ST   = 4'd5,
    XC_BUS_FETCH = 4'd6,
    XC_BUS_DATA  = 4'd7,
    XC_SYSCALL   = 4'd8,
    XC_BREAK     = 4'd9,
    XC_RSVD_INSN = 4'd10,
    XC_OVERFLOW  = 4'd12
  } xc_code_e;

  typedef enum logic [1:0] {
    RSEL_STATUS = 2'd0,
    RSEL_CAUSE  = 2'd1,
    RSEL_EPC    = 2'd2,
    RSEL_NONE   = 2'd3
  } rsel_e;

endpackage

// File: rtl/exc_epc_reg.sv
module exc_epc_reg #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [XLEN-1:0] pc,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] epc_q
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_ff @(posedge clk) begin
    if (rst)       epc_q <= '0;
    else if (take) epc_q <= pc - STEP;
    else if (we)   epc_q <= wdata;
  end

  a_r2_epc_offset: assert property (@(posedge clk) disable iff (rst)
    take |=> epc_q == $past(pc) - STEP);

  a_r11_epc_write: assert property (@(posedge clk) disable iff (rst)
    (!take && we) |=> epc_q == $past(wdata));

endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
  import exc_pkg::*;
#(
  parameter int NHW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [CODE_W-1:0] code_in,
  input  logic              we,
  input  logic [CODE_W-1:0] wcode,
  input  logic [NHW-1:0]    wpend,
  input  logic [NHW-1:0]    hw_irq,
  output logic [CODE_W-1:0] code_q,
  output logic [NHW-1:0]    pend_q
);

  logic sw_load;
  assign sw_load = we && !take;

  always_ff @(posedge clk) begin
    if (rst)          code_q <= '0;
    else if (take)    code_q <= code_in;
    else if (sw_load) code_q <= wcode;
  end

  for (genvar i = 0; i < NHW; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (rst)          pend_q[i] <= 1'b0;
      else if (sw_load) pend_q[i] <= wpend[i] | hw_irq[i];
      else              pend_q[i] <= pend_q[i] | hw_irq[i];
    end
  end

  a_r4_code_load: assert property (@(posedge clk) disable iff (rst)
    take |=> code_q == $past(code_in));

  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    !sw_load |=> (pend_q & $past(pend_q | hw_irq)) == $past(pend_q | hw_irq));

endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic               eret,
  input  logic               we,
  input  logic [MASK_W-1:0]  wmask,
  input  logic [STACK_W-1:0] wstack,
  output logic [MASK_W-1:0]  mask_q,
  output logic [STACK_W-1:0] stack_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      stack_q <= '0;
    end else if (take) begin
      stack_q <= {stack_q[STACK_W-3:0], 2'b00};
    end else if (eret) begin
      stack_q <= {stack_q[STACK_W-1:STACK_W-2], stack_q[STACK_W-1:2]};
    end else if (we) begin
      mask_q  <= wmask;
      stack_q <= wstack;
    end
  end

  a_r6_push: assert property (@(posedge clk) disable iff (rst)
    take |=> (stack_q[5:2] == $past(stack_q[3:0])) && (stack_q[1:0] == 2'b00)
             && (mask_q == $past(mask_q)));

  a_r7_pop: assert property (@(posedge clk) disable iff (rst)
    (eret && !take) |=> (stack_q[3:0] == $past(stack_q[5:2]))
                        && (stack_q[5:4] == $past(stack_q[5:4])));

endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
  import exc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              NHW        = 6,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] VEC_ADDR   = 32'h8000_0080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_req,
  input  logic [3:0]        exc_code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              eret,
  input  logic [NHW-1:0]    hw_irq,
  input  logic              sw_we_epc,
  input  logic              sw_we_cause,
  input  logic              sw_we_status,
  input  logic [XLEN-1:0]   sw_wdata,
  input  logic [1:0]        rd_sel,
  output logic [XLEN-1:0]   rd_data,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              irq_req
);

  localparam int HW_MASK_OFS = PEND_LO - MASK_LO;

  logic [XLEN-1:0]    epc_q;
  logic [CODE_W-1:0]  code_q;
  logic [NHW-1:0]     pend_q;
  logic [MASK_W-1:0]  mask_q;
  logic [STACK_W-1:0] stack_q;
  logic [XLEN-1:0]    status_word, cause_word, rd_next;
  logic               irq_next;

  exc_epc_reg #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_epc (
    .clk(clk), .rst(rst), .take(exc_req), .pc(cur_pc),
    .we(sw_we_epc), .wdata(sw_wdata), .epc_q(epc_q));

  exc_cause_reg #(.NHW(NHW)) u_cause (
    .clk(clk), .rst(rst), .take(exc_req), .code_in(exc_code),
    .we(sw_we_cause), .wcode(sw_wdata[CODE_LO +: CODE_W]),
    .wpend(sw_wdata[PEND_LO +: NHW]), .hw_irq(hw_irq),
    .code_q(code_q), .pend_q(pend_q));

  exc_status_reg u_status (
    .clk(clk), .rst(rst), .take(exc_req), .eret(eret), .we(sw_we_status),
    .wmask(sw_wdata[MASK_LO +: MASK_W]), .wstack(sw_wdata[STACK_W-1:0]),
    .mask_q(mask_q), .stack_q(stack_q));

  always_comb begin
    status_word = '0;
    status_word[MASK_LO +: MASK_W] = mask_q;
    status_word[STACK_W-1:0]       = stack_q;
    cause_word = '0;
    cause_word[PEND_LO +: NHW]     = pend_q;
    cause_word[CODE_LO +: CODE_W]  = code_q;
  end

  always_comb begin
    unique case (rsel_e'(rd_sel))
      RSEL_STATUS: rd_next = status_word;
      RSEL_CAUSE:  rd_next = cause_word;
      RSEL_EPC:    rd_next = epc_q;
      default:     rd_next = '0;
    endcase
  end

  assign irq_next = stack_q[0] && |(pend_q & mask_q[HW_MASK_OFS +: NHW]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data        <= '0;
      redirect_valid <= 1'b0;
      irq_req        <= 1'b0;
    end else begin
      rd_data        <= rd_next;
      redirect_valid <= exc_req;
      irq_req        <= irq_next;
    end
  end

  assign redirect_pc = VEC_ADDR;

  a_r3_redirect: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> redirect_valid && redirect_pc == VEC_ADDR);

  a_r3_no_redirect: assert property (@(posedge clk) disable iff (rst)
    !exc_req |=> !redirect_valid);

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
    !stack_q[0] |=> !irq_req);

endmodule

// File: tb/sim_exc_ctrl_regs.sv
module sim_exc_ctrl_regs;

  logic        clk = 1'b0;
  logic        rst;
  logic        exc_req, eret, sw_we_epc, sw_we_cause, sw_we_status;
  logic [3:0]  exc_code;
  logic [31:0] cur_pc, sw_wdata, rd_data, redirect_pc;
  logic [5:0]  hw_irq;
  logic [1:0]  rd_sel;
  logic        redirect_valid, irq_req;

  always #5 clk = ~clk;

  exc_ctrl_regs u0 (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code),
    .cur_pc(cur_pc), .eret(eret), .hw_irq(hw_irq), .sw_we_epc(sw_we_epc),
    .sw_we_cause(sw_we_cause), .sw_we_status(sw_we_status),
    .sw_wdata(sw_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .irq_req(irq_req));

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic        rv;
    logic        irq;
  } exp_t;

  typedef struct {
    logic        exc;
    logic [3:0]  code;
    logic [31:0] pc;
    logic        er;
    logic [5:0]  irq;
    logic        wepc, wcause, wstat;
    logic [31:0] wd;
    logic [1:0]  sel;
  } stim_t;

  exp_t q[$];
  int   n_cmp = 0, n_bad = 0;
  bit   done = 0;

  // reference state, kept from the requirements
  logic [31:0] m_epc;
  logic [3:0]  m_code;
  logic [5:0]  m_pend;
  logic [7:0]  m_mask;
  logic [5:0]  m_stack;

  function automatic stim_t idle(input logic [1:0] sel);
    stim_t s;
    s.exc = 0; s.code = 0; s.pc = 0; s.er = 0; s.irq = 0;
    s.wepc = 0; s.wcause = 0; s.wstat = 0; s.wd = 0; s.sel = sel;
    return s;
  endfunction

  function automatic logic [31:0] m_word(input logic [1:0] sel);
    case (sel)
      2'd0: return {16'h0, m_mask, 2'b00, m_stack};
      2'd1: return {16'h0, m_pend, 4'h0, m_code, 2'b00};
      2'd2: return m_epc;
      default: return 32'h0;
    endcase
  endfunction

  task automatic drive(input string tag, input stim_t s);
    exp_t e;
    @(negedge clk);
    exc_req = s.exc; exc_code = s.code; cur_pc = s.pc; eret = s.er;
    hw_irq = s.irq; sw_we_epc = s.wepc; sw_we_cause = s.wcause;
    sw_we_status = s.wstat; sw_wdata = s.wd; rd_sel = s.sel;
    e.tag = tag;
    e.rd  = m_word(s.sel);
    e.rv  = s.exc;
    e.irq = m_stack[0] && |(m_pend & m_mask[7:2]);
    q.push_back(e);
    // R9 priorities in the reference update
    if (s.exc) begin
      m_epc   = s.pc - 32'd4;
      m_code  = s.code;
      m_pend  = m_pend | s.irq;
      m_stack = {m_stack[3:0], 2'b00};
    end else begin
      if (s.wepc) m_epc = s.wd;
      if (s.wcause) begin
        m_code = s.wd[5:2];
        m_pend = s.wd[15:10] | s.irq;
      end else m_pend = m_pend | s.irq;
      if (s.er) m_stack = {m_stack[5:4], m_stack[5:2]};
      else if (s.wstat) begin
        m_mask = s.wd[15:8]; m_stack = s.wd[5:0];
      end
    end
  endtask

  task automatic read_all(input string tag);
    drive(tag, idle(2'd0));
    drive(tag, idle(2'd1));
    drive(tag, idle(2'd2));
    drive(tag, idle(2'd3));
  endtask

  // monitor: compares each item one step after the edge it belongs to
  always @(posedge clk) begin
    #2;
    if (q.size() > 0 && !done) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (rd_data !== e.rd || redirect_valid !== e.rv || irq_req !== e.irq ||
          (redirect_valid && redirect_pc !== 32'h8000_0080)) begin
        n_bad++;
        $display("FAIL %s: rd=%h rv=%b irq=%b pc=%h expected rd=%h rv=%b irq=%b pc=80000080",
                 e.tag, rd_data, redirect_valid, irq_req, redirect_pc,
                 e.rd, e.rv, e.irq);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    stim_t s;
    logic [15:0] lfsr = 16'hACE1;
    rst = 1; exc_req = 0; exc_code = 0; cur_pc = 0; eret = 0; hw_irq = 0;
    sw_we_epc = 0; sw_we_cause = 0; sw_we_status = 0; sw_wdata = 0; rd_sel = 0;
    m_epc = 0; m_code = 0; m_pend = 0; m_mask = 0; m_stack = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    read_all("R1 reset state");

    // R11: status write, bits outside fields dropped; enable on
    s = idle(2'd0); s.wstat = 1; s.wd = 32'hFFFF_FF3F;
    drive("R11 status write", s);
    drive("R11 status readback", idle(2'd0));

    // R5/R8: pulse line 2, interrupt request follows
    s = idle(2'd1); s.irq = 6'b000100;
    drive("R5 pending latch", s);
    drive("R8 irq raised", idle(2'd1));
    drive("R8 irq held", idle(2'd1));

    // R2/R3/R4/R6: overflow entry
    s = idle(2'd0); s.exc = 1; s.code = 4'd12; s.pc = 32'h0040_0024;
    drive("R2 R3 overflow entry", s);
    drive("R3 R6 after entry", idle(2'd0));
    read_all("R2 R4 R6 overflow state");

    // R5: latch while disabled
    s = idle(2'd1); s.irq = 6'b100000;
    drive("R5 latch while disabled", s);
    drive("R5 pending kept", idle(2'd1));
    drive("R5 pending kept", idle(2'd1));

    // R7: return pops the stack
    s = idle(2'd0); s.er = 1;
    drive("R7 eret pop", s);
    drive("R7 status after pop", idle(2'd0));
    drive("R8 irq after pop", idle(2'd0));

    // R9: entry wins over software writes and eret
    s = idle(2'd2); s.exc = 1; s.code = 4'd10; s.pc = 32'h0000_1000;
    s.wepc = 1; s.wcause = 1; s.wstat = 1; s.er = 1; s.wd = 32'h1234_5678;
    drive("R9 undefined entry with writes", s);
    read_all("R4 R9 undefined state");

    // R9: eret wins over status write
    s = idle(2'd0); s.er = 1; s.wstat = 1; s.wd = 32'h0000_0000;
    drive("R9 eret over status write", s);
    drive("R9 status after", idle(2'd0));

    // R5: cause write clears pending but keeps a line high this cycle
    s = idle(2'd1); s.wcause = 1; s.wd = 32'h0000_0424; s.irq = 6'b000010;
    drive("R5 cause write clear", s);
    drive("R5 cause after write", idle(2'd1));
    drive("R8 irq after clear", idle(2'd1));

    // R11: full EPC write
    s = idle(2'd2); s.wepc = 1; s.wd = 32'hDEAD_BEEF;
    drive("R11 epc write", s);
    drive("R11 epc readback", idle(2'd2));
    drive("R10 zero select", idle(2'd3));

    // mixed traffic, all codes
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = idle(lfsr[1:0]);
      s.exc    = (lfsr[6:3] == 4'd0);
      s.code   = lfsr[15:12];
      s.pc     = {lfsr, lfsr[7:0], 8'h04};
      s.er     = (lfsr[9:7] == 3'd1);
      s.irq    = (lfsr[11:9] == 3'd2) ? lfsr[15:10] : 6'b0;
      s.wepc   = (lfsr[5:3] == 3'd5);
      s.wcause = (lfsr[8:5] == 4'd3);
      s.wstat  = (lfsr[10:8] == 3'd6);
      s.wd     = {lfsr, ~lfsr};
      drive("R10 mixed traffic", s);
    end
    read_all("R10 final state");

    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule